// File: doc/BRIEF.md
# Transceiver Power and Reset Sequencer

This block brings a serial transceiver macro up, takes it down and resets it by running a fixed series of register operations. It drives those operations through a simple register port with one strobe at a time. Three command inputs start the three sequences. Each state-field update is a read followed by a write that changes only the addressed field. Status bits are sampled on a fixed poll interval and under an overall time limit. A microsecond tick paces every interval, so the sequencer does not depend on the clock rate.

Power-up enables the PLL and waits for it to report ready. It then enables the transmitter and the receiver, and waits for the clock unit to report good. Power-down disables the transmitter and receiver before the PLL. Reset forces the disable codes and then pulses the power-on-reset bit for a timed interval. A `busy` output covers each sequence. The sequence ends with a one-cycle `done` or `timeout` pulse.

Top module: `serpwr_seq`

## Requirements
- R1: Out of reset, `busy`, `done`, `timeout`, `reg_wr` and `reg_rd` are all low.
- R2: The 3-bit power-state codes are disable 3'b100, sleep 3'b101, snooze 3'b110 and enable 3'b111. Power-up begins by writing enable into bits 31:29 of the PLL control word.
- R3: After the PLL write, bit 28 of the PLL control word is read at once. While it reads 0, it is read again every PLL_POLL_US ticks, so consecutive polls are PLL_POLL_US+1 cycles apart when a tick arrives every cycle. No lane write happens before it reads 1.
- R4: Once the PLL is ready, enable is written first to the transmit field (bits 31:29) of the lane word and then to the receive field (bits 15:13).
- R5: Bit CMU_OK_BIT (19) of the status word is then polled every CMU_POLL_US ticks. `done` pulses only after a read returns 1.
- R6: A poll read that finds its bit clear once at least TIMEOUT_US ticks have passed since the first poll of that wait ends the sequence. It gives a one-cycle `timeout` pulse, makes no further bus access and leaves every written field in place. With a tick every cycle, the PLL wait thus makes 1+ceil(TIMEOUT_US/(PLL_POLL_US+1)) poll reads.
- R7: Power-down writes disable to the transmit field, then to the receive field, then to the PLL field.
- R8: Reset writes disable to the PLL, transmit and receive fields in that order. It then sets bit 29 of the control word and holds it for at least POR_HOLD_US ticks before clearing it.
- R9: Every field update reads the word and then writes it back in the next cycle. All bits outside the field keep the value that was read.
- R10: `busy` rises the cycle after a command is accepted. It stays high until the cycle in which `done` or `timeout` pulses for one cycle, with `busy` low. Commands that arrive while `busy` is high are ignored.
- R11: When several commands arrive in the same idle cycle, reset wins over power-down, and power-down wins over power-up.
- R12: `reg_rd` and `reg_wr` are never high together. `reg_rdata` is sampled in the same cycle as `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| cmd_up | input | 1 | Start power-up |
| cmd_down | input | 1 | Start power-down |
| cmd_reset | input | 1 | Start reset sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | One-cycle pulse on a failed status poll |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | ADDR_W | Word address of the access |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid in the cycle of `reg_rd` |

## Verification
The bench covers three cases where two things meet in one cycle. First, it raises all three commands together, and then power-down and power-up together. The exact write stream on the bus, compared item by item against the expected queue, shows which sequence won the priority. Second, a reset command pulsed in the middle of a power-up poll tests command rejection during `busy`: any extra write from the ignored command would show up as an unexpected scoreboard item. Third, for timeouts, the bench holds a status bit low and counts the poll reads before the `timeout` pulse, which exercises the cycle where a poll read and the time limit coincide.

// File: rtl/serpwr_pkg.sv
package serpwr_pkg;

  localparam int STEP_W = 3;

  localparam logic [2:0] PS_DISABLE = 3'b100;
  localparam logic [2:0] PS_SLEEP   = 3'b101;
  localparam logic [2:0] PS_SNOOZE  = 3'b110;
  localparam logic [2:0] PS_ENABLE  = 3'b111;

  typedef enum logic [1:0] {
    OP_RMW  = 2'd0,
    OP_POLL = 2'd1,
    OP_HOLD = 2'd2,
    OP_END  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    TGT_PLL  = 2'd0,
    TGT_LANE = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_STAT = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    SEQ_UP   = 2'd0,
    SEQ_DOWN = 2'd1,
    SEQ_RST  = 2'd2
  } seq_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DISP  = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_PRD   = 3'd4,
    ST_PWAIT = 3'd5,
    ST_HOLD  = 3'd6
  } st_e;

  typedef struct packed {
    op_e        op;
    tgt_e       tgt;
    logic [4:0] lsb;
    logic [2:0] fmask;
    logic [2:0] val;
  } step_t;

endpackage

// File: rtl/serpwr_step_rom.sv
module serpwr_step_rom
  import serpwr_pkg::*;
#(
  parameter int PLL_FLD_LSB = 29,
  parameter int PLL_OK_BIT  = 28,
  parameter int TX_FLD_LSB  = 29,
  parameter int RX_FLD_LSB  = 13,
  parameter int POR_BIT     = 29,
  parameter int CMU_OK_BIT  = 19
) (
  input  seq_e              seq_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);

  function automatic step_t mk(op_e op, tgt_e tgt, int lsb, logic [2:0] fm, logic [2:0] v);
    step_t s;
    s.op    = op;
    s.tgt   = tgt;
    s.lsb   = 5'(lsb);
    s.fmask = fm;
    s.val   = v;
    return s;
  endfunction

  localparam step_t S_END = '{op: OP_END, tgt: TGT_PLL, lsb: 5'd0, fmask: 3'd0, val: 3'd0};

  always_comb begin
    step_o = S_END;
    unique case (seq_i)
      SEQ_UP: begin
        case (idx_i)
          3'd0: step_o = mk(OP_RMW,  TGT_PLL,  PLL_FLD_LSB, 3'b111, PS_ENABLE);
          3'd1: step_o = mk(OP_POLL, TGT_PLL,  PLL_OK_BIT,  3'b001, 3'd0);
          3'd2: step_o = mk(OP_RMW,  TGT_LANE, TX_FLD_LSB,  3'b111, PS_ENABLE);
          3'd3: step_o = mk(OP_RMW,  TGT_LANE, RX_FLD_LSB,  3'b111, PS_ENABLE);
          3'd4: step_o = mk(OP_POLL, TGT_STAT, CMU_OK_BIT,  3'b001, 3'd0);
          default: step_o = S_END;
        endcase
      end
      SEQ_DOWN: begin
        case (idx_i)
          3'd0: step_o = mk(OP_RMW, TGT_LANE, TX_FLD_LSB,  3'b111, PS_DISABLE);
          3'd1: step_o = mk(OP_RMW, TGT_LANE, RX_FLD_LSB,  3'b111, PS_DISABLE);
          3'd2: step_o = mk(OP_RMW, TGT_PLL,  PLL_FLD_LSB, 3'b111, PS_DISABLE);
          default: step_o = S_END;
        endcase
      end
      SEQ_RST: begin
        case (idx_i)
          3'd0: step_o = mk(OP_RMW,  TGT_PLL,  PLL_FLD_LSB, 3'b111, PS_DISABLE);
          3'd1: step_o = mk(OP_RMW,  TGT_LANE, TX_FLD_LSB,  3'b111, PS_DISABLE);
          3'd2: step_o = mk(OP_RMW,  TGT_LANE, RX_FLD_LSB,  3'b111, PS_DISABLE);
          3'd3: step_o = mk(OP_RMW,  TGT_CTRL, POR_BIT,     3'b001, 3'b001);
          3'd4: step_o = mk(OP_HOLD, TGT_CTRL, POR_BIT,     3'b001, 3'd0);
          3'd5: step_o = mk(OP_RMW,  TGT_CTRL, POR_BIT,     3'b001, 3'b000);
          default: step_o = S_END;
        endcase
      end
      default: step_o = S_END;
    endcase
  end

endmodule

// File: rtl/serpwr_merge.sv
module serpwr_merge
  import serpwr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_i,
  input  step_t         step_i,
  output logic [DW-1:0] new_o
);

  logic [DW-1:0] mask_w;
  logic [DW-1:0] ins_w;

  always_comb begin
    mask_w = {{(DW-3){1'b0}}, step_i.fmask} << step_i.lsb;
    ins_w  = {{(DW-3){1'b0}}, (step_i.val & step_i.fmask)} << step_i.lsb;
    new_o  = (old_i & ~mask_w) | ins_w;
  end

endmodule

// File: rtl/serpwr_timer.sv
module serpwr_timer #(
  parameter int IVL_W      = 10,
  parameter int ELAP_W     = 18,
  parameter int TIMEOUT_US = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ivl_clr_i,
  input  logic             ivl_run_i,
  input  logic [IVL_W-1:0] ivl_limit_i,
  input  logic             elap_clr_i,
  input  logic             elap_run_i,
  output logic             ivl_hit_o,
  output logic             elap_over_o
);

  logic [IVL_W-1:0]  ivl_q, ivl_d;
  logic              ivl_en;
  logic [ELAP_W-1:0] elap_q, elap_d;
  logic              elap_en;

  assign ivl_hit_o   = ivl_run_i && tick_i && (ivl_q == ivl_limit_i - IVL_W'(1));
  assign elap_over_o = (elap_q >= ELAP_W'(TIMEOUT_US));

  always_comb begin
    ivl_en = 1'b0;
    ivl_d  = ivl_q;
    if (ivl_clr_i) begin
      ivl_en = 1'b1;
      ivl_d  = '0;
    end else if (ivl_run_i && tick_i) begin
      ivl_en = 1'b1;
      ivl_d  = ivl_hit_o ? '0 : ivl_q + IVL_W'(1);
    end
  end

  always_comb begin
    elap_en = 1'b0;
    elap_d  = elap_q;
    if (elap_clr_i) begin
      elap_en = 1'b1;
      elap_d  = '0;
    end else if (elap_run_i && tick_i && !elap_over_o) begin
      elap_en = 1'b1;
      elap_d  = elap_q + ELAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      elap_q <= '0;
    end else begin
      if (ivl_en)  ivl_q  <= ivl_d;
      if (elap_en) elap_q <= elap_d;
    end
  end

endmodule

// File: rtl/serpwr_ctrl.sv
module serpwr_ctrl
  import serpwr_pkg::*;
#(
  parameter int IVL_W       = 10,
  parameter int PLL_POLL_US = 1000,
  parameter int CMU_POLL_US = 100,
  parameter int POR_HOLD_US = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_up_i,
  input  logic              cmd_down_i,
  input  logic              cmd_reset_i,
  input  step_t             step_i,
  input  logic [31:0]       rdata_i,
  input  logic              ivl_hit_i,
  input  logic              elap_over_i,
  output seq_e              seq_o,
  output logic [STEP_W-1:0] idx_o,
  output logic [31:0]       shadow_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              ivl_clr_o,
  output logic              ivl_run_o,
  output logic [IVL_W-1:0]  ivl_limit_o,
  output logic              elap_clr_o,
  output logic              elap_run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  st_e               st_q, st_d;
  seq_e              seq_q, seq_d;
  logic              seq_en;
  logic [STEP_W-1:0] idx_q, idx_d;
  logic              idx_en;
  logic [31:0]       shadow_q;
  logic              shadow_en;
  logic              done_q, done_d;
  logic              to_q, to_d;
  logic              poll_bit;

  assign poll_bit = rdata_i[step_i.lsb];

  always_comb begin
    st_d       = st_q;
    seq_d      = seq_q;
    seq_en     = 1'b0;
    idx_d      = idx_q;
    idx_en     = 1'b0;
    shadow_en  = 1'b0;
    done_d     = 1'b0;
    to_d       = 1'b0;
    ivl_clr_o  = 1'b0;
    elap_clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_reset_i || cmd_down_i || cmd_up_i) begin
          seq_en = 1'b1;
          seq_d  = cmd_reset_i ? SEQ_RST : (cmd_down_i ? SEQ_DOWN : SEQ_UP);
          idx_en = 1'b1;
          idx_d  = '0;
          st_d   = ST_DISP;
        end
      end
      ST_DISP: begin
        unique case (step_i.op)
          OP_RMW:  st_d = ST_RD;
          OP_POLL: begin
            elap_clr_o = 1'b1;
            st_d       = ST_PRD;
          end
          OP_HOLD: begin
            ivl_clr_o = 1'b1;
            st_d      = ST_HOLD;
          end
          default: begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        endcase
      end
      ST_RD: begin
        shadow_en = 1'b1;
        st_d      = ST_WR;
      end
      ST_WR: begin
        idx_en = 1'b1;
        idx_d  = idx_q + STEP_W'(1);
        st_d   = ST_DISP;
      end
      ST_PRD: begin
        if (poll_bit) begin
          idx_en = 1'b1;
          idx_d  = idx_q + STEP_W'(1);
          st_d   = ST_DISP;
        end else if (elap_over_i) begin
          to_d = 1'b1;
          st_d = ST_IDLE;
        end else begin
          ivl_clr_o = 1'b1;
          st_d      = ST_PWAIT;
        end
      end
      ST_PWAIT: begin
        if (ivl_hit_i) st_d = ST_PRD;
      end
      ST_HOLD: begin
        if (ivl_hit_i) begin
          idx_en = 1'b1;
          idx_d  = idx_q + STEP_W'(1);
          st_d   = ST_DISP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      seq_q    <= SEQ_UP;
      idx_q    <= '0;
      shadow_q <= '0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      to_q   <= to_d;
      if (seq_en)    seq_q    <= seq_d;
      if (idx_en)    idx_q    <= idx_d;
      if (shadow_en) shadow_q <= rdata_i;
    end
  end

  assign seq_o      = seq_q;
  assign idx_o      = idx_q;
  assign shadow_o   = shadow_q;
  assign rd_o       = (st_q == ST_RD) || (st_q == ST_PRD);
  assign wr_o       = (st_q == ST_WR);
  assign ivl_run_o  = (st_q == ST_PWAIT) || (st_q == ST_HOLD);
  assign elap_run_o = (st_q == ST_PRD) || (st_q == ST_PWAIT);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = to_q;

  assign ivl_limit_o = (step_i.op == OP_HOLD)  ? IVL_W'(POR_HOLD_US) :
                       (step_i.tgt == TGT_STAT) ? IVL_W'(CMU_POLL_US) :
                                                  IVL_W'(PLL_POLL_US);

endmodule

// File: rtl/serpwr_seq.sv
module serpwr_seq
  import serpwr_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] PLL_ADDR  = 8'h3F,
  parameter logic [ADDR_W-1:0] LANE_ADDR = 8'h3E,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20,
  parameter int PLL_POLL_US  = 1000,
  parameter int CMU_POLL_US  = 100,
  parameter int TIMEOUT_US   = 100000,
  parameter int POR_HOLD_US  = 1000,
  parameter int PLL_FLD_LSB  = 29,
  parameter int PLL_OK_BIT   = 28,
  parameter int TX_FLD_LSB   = 29,
  parameter int RX_FLD_LSB   = 13,
  parameter int POR_BIT      = 29,
  parameter int CMU_OK_BIT   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              cmd_up,
  input  logic              cmd_down,
  input  logic              cmd_reset,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);

  localparam int IVL_MAX0 = (PLL_POLL_US > CMU_POLL_US) ? PLL_POLL_US : CMU_POLL_US;
  localparam int IVL_MAX  = (IVL_MAX0 > POR_HOLD_US) ? IVL_MAX0 : POR_HOLD_US;
  localparam int IVL_W    = $clog2(IVL_MAX + 1);
  localparam int ELAP_W   = $clog2(TIMEOUT_US + 1) + 1;

  seq_e              seq_w;
  logic [STEP_W-1:0] idx_w;
  step_t             step_w;
  logic [31:0]       shadow_w;
  logic              ivl_clr_w, ivl_run_w, elap_clr_w, elap_run_w;
  logic [IVL_W-1:0]  ivl_limit_w;
  logic              ivl_hit_w, elap_over_w;

  serpwr_step_rom #(
    .PLL_FLD_LSB (PLL_FLD_LSB),
    .PLL_OK_BIT  (PLL_OK_BIT),
    .TX_FLD_LSB  (TX_FLD_LSB),
    .RX_FLD_LSB  (RX_FLD_LSB),
    .POR_BIT     (POR_BIT),
    .CMU_OK_BIT  (CMU_OK_BIT)
  ) u_rom (
    .seq_i  (seq_w),
    .idx_i  (idx_w),
    .step_o (step_w)
  );

  serpwr_merge #(.DW(32)) u_merge (
    .old_i  (shadow_w),
    .step_i (step_w),
    .new_o  (reg_wdata)
  );

  serpwr_timer #(
    .IVL_W      (IVL_W),
    .ELAP_W     (ELAP_W),
    .TIMEOUT_US (TIMEOUT_US)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (us_tick),
    .ivl_clr_i   (ivl_clr_w),
    .ivl_run_i   (ivl_run_w),
    .ivl_limit_i (ivl_limit_w),
    .elap_clr_i  (elap_clr_w),
    .elap_run_i  (elap_run_w),
    .ivl_hit_o   (ivl_hit_w),
    .elap_over_o (elap_over_w)
  );

  serpwr_ctrl #(
    .IVL_W       (IVL_W),
    .PLL_POLL_US (PLL_POLL_US),
    .CMU_POLL_US (CMU_POLL_US),
    .POR_HOLD_US (POR_HOLD_US)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_up_i    (cmd_up),
    .cmd_down_i  (cmd_down),
    .cmd_reset_i (cmd_reset),
    .step_i      (step_w),
    .rdata_i     (reg_rdata),
    .ivl_hit_i   (ivl_hit_w),
    .elap_over_i (elap_over_w),
    .seq_o       (seq_w),
    .idx_o       (idx_w),
    .shadow_o    (shadow_w),
    .rd_o        (reg_rd),
    .wr_o        (reg_wr),
    .ivl_clr_o   (ivl_clr_w),
    .ivl_run_o   (ivl_run_w),
    .ivl_limit_o (ivl_limit_w),
    .elap_clr_o  (elap_clr_w),
    .elap_run_o  (elap_run_w),
    .busy_o      (busy),
    .done_o      (done),
    .timeout_o   (timeout)
  );

  always_comb begin
    unique case (step_w.tgt)
      TGT_PLL:  reg_addr = PLL_ADDR;
      TGT_LANE: reg_addr = LANE_ADDR;
      TGT_CTRL: reg_addr = CTRL_ADDR;
      default:  reg_addr = STAT_ADDR;
    endcase
  end

endmodule

// File: rtl/serpwr_seq_chk.sv
module serpwr_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_up,
  input logic              cmd_down,
  input logic              cmd_reset,
  input logic              busy,
  input logic              done,
  input logic              timeout,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr
);

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(reg_wr || reg_rd));

  assert_wr_after_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($past(reg_rd) && ($past(reg_addr) == reg_addr)));

  assert_start_by_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_up || cmd_down || cmd_reset));

  assert_end_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || timeout));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);

  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

endmodule

bind serpwr_seq serpwr_seq_chk #(.ADDR_W(ADDR_W)) u_serpwr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_up    (cmd_up),
  .cmd_down  (cmd_down),
  .cmd_reset (cmd_reset),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr)
);

// File: tb/serpwr_seq_tb_top.sv
`timescale 1ns/1ps
module serpwr_seq_tb_top;

  localparam logic [7:0] A_PLL  = 8'h3F;
  localparam logic [7:0] A_LANE = 8'h3E;
  localparam logic [7:0] A_CTRL = 8'h3D;
  localparam logic [7:0] A_STAT = 8'h20;
  localparam int T_PLL_POLL = 10;
  localparam int T_CMU_POLL = 4;
  localparam int T_TO       = 60;
  localparam int T_POR      = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic us_tick, cmd_up, cmd_down, cmd_reset;
  logic busy, done, timeout, reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  serpwr_seq #(
    .ADDR_W(8), .PLL_ADDR(A_PLL), .LANE_ADDR(A_LANE), .CTRL_ADDR(A_CTRL), .STAT_ADDR(A_STAT),
    .PLL_POLL_US(T_PLL_POLL), .CMU_POLL_US(T_CMU_POLL), .TIMEOUT_US(T_TO), .POR_HOLD_US(T_POR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_up(cmd_up), .cmd_down(cmd_down),
    .cmd_reset(cmd_reset), .busy(busy), .done(done), .timeout(timeout), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // transceiver register model driven by the bus
  logic [31:0] mem_pll  = 32'h0A5C_3E11;
  logic [31:0] mem_lane = 32'h5A5A_A5A5;
  logic [31:0] mem_ctrl = 32'hC3C3_0F0F;
  logic pll_ok, cmu_ok;

  always @(posedge clk) begin
    if (reg_wr) begin
      case (reg_addr)
        A_PLL:  mem_pll  <= reg_wdata;
        A_LANE: mem_lane <= reg_wdata;
        A_CTRL: mem_ctrl <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_PLL:   reg_rdata = {mem_pll[31:29], pll_ok, mem_pll[27:0]};
      A_LANE:  reg_rdata = mem_lane;
      A_CTRL:  reg_rdata = mem_ctrl;
      default: reg_rdata = 32'h00F0_0ABC | ({31'b0, cmu_ok} << 19);
    endcase
  end

  // expected model and scoreboard
  logic [31:0] m_pll  = 32'h0A5C_3E11;
  logic [31:0] m_lane = 32'h5A5A_A5A5;
  logic [31:0] m_ctrl = 32'hC3C3_0F0F;
  logic [39:0] exp_q[$];

  int chk_n = 0, chk_bad = 0;
  int sb_n = 0, sb_bad = 0;
  int wd_bad = 0;
  int done_cnt = 0, to_cnt = 0, wr_seen = 0;
  int cyc = 0;
  int rd_n = 0;
  int rd_log[32];
  int ctrl_n = 0;
  int ctrl_log[8];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] fmerge(logic [31:0] old, int lsb, logic [2:0] fm, logic [2:0] v);
    logic [31:0] m;
    m = {29'b0, fm} << lsb;
    return (old & ~m) | (({29'b0, v} & {29'b0, fm}) << lsb);
  endfunction

  // driver side: push expected writes
  task automatic push_rmw(input int which, input int lsb, input logic [2:0] fm, input logic [2:0] v);
    logic [31:0] nv;
    case (which)
      0: begin nv = fmerge({m_pll[31:29], pll_ok, m_pll[27:0]}, lsb, fm, v); m_pll = nv; exp_q.push_back({A_PLL, nv}); end
      1: begin nv = fmerge(m_lane, lsb, fm, v); m_lane = nv; exp_q.push_back({A_LANE, nv}); end
      default: begin nv = fmerge(m_ctrl, lsb, fm, v); m_ctrl = nv; exp_q.push_back({A_CTRL, nv}); end
    endcase
  endtask

  task automatic push_reset_seq();
    push_rmw(0, 29, 3'b111, 3'b100);
    push_rmw(1, 29, 3'b111, 3'b100);
    push_rmw(1, 13, 3'b111, 3'b100);
    push_rmw(2, 29, 3'b001, 3'b001);
    push_rmw(2, 29, 3'b001, 3'b000);
  endtask

  task automatic push_down_seq();
    push_rmw(1, 29, 3'b111, 3'b100);
    push_rmw(1, 13, 3'b111, 3'b100);
    push_rmw(0, 29, 3'b111, 3'b100);
  endtask

  // monitor: compare writes as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (timeout) to_cnt++;
      if (reg_rd && reg_addr == A_PLL && rd_n < 32) begin
        rd_log[rd_n] = cyc;
        rd_n++;
      end
      if (reg_wr) begin
        wr_seen++;
        sb_n++;
        if (reg_addr == A_CTRL && ctrl_n < 8) begin
          ctrl_log[ctrl_n] = cyc;
          ctrl_n++;
        end
        if (exp_q.size() == 0) begin
          sb_bad++;
          $display("FAIL R9 unexpected write: act addr=%h data=%h exp none", reg_addr, reg_wdata);
        end else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          if ({reg_addr, reg_wdata} !== e) begin
            sb_bad++;
            $display("FAIL R9 write order/data: act addr=%h data=%h exp addr=%h data=%h",
                     reg_addr, reg_wdata, e[39:32], e[31:0]);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    chk_n++;
    if (!ok) begin
      chk_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic fire(input logic u, input logic d, input logic r);
    @(posedge clk); #1;
    cmd_up = u; cmd_down = d; cmd_reset = r;
    @(posedge clk); #1;
    cmd_up = 0; cmd_down = 0; cmd_reset = 0;
  endtask

  task automatic wait_end();
    int d0, t0, n;
    d0 = done_cnt; t0 = to_cnt; n = 0;
    while (done_cnt == d0 && to_cnt == t0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chk_n + sb_n + wd_bad, chk_bad + sb_bad + wd_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      wd_bad = 1;
      $display("FAIL watchdog: act=running exp=finished");
      report();
      $finish;
    end
  end

  initial begin
    int d0, t0, w0, k, exp_reads;
    rst_n = 0; us_tick = 0; cmd_up = 0; cmd_down = 0; cmd_reset = 0;
    pll_ok = 0; cmu_ok = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1; us_tick = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(timeout == 0, "R1 timeout", timeout, 0);
    chk((reg_wr | reg_rd) == 0, "R1 strobes", reg_wr | reg_rd, 0);

    // power-up with delayed ready bits; R2 R3 R4 R5 R10
    d0 = done_cnt; t0 = to_cnt;
    push_rmw(0, 29, 3'b111, 3'b111);
    fire(1, 0, 0);
    repeat (40) @(negedge clk);
    chk(wr_seen == 1, "R3 no lane write before PLL ready", wr_seen, 1);
    chk(busy == 1, "R10 busy during sequence", busy, 1);
    fire(0, 0, 1); // ignored while busy
    push_rmw(1, 29, 3'b111, 3'b111);
    push_rmw(1, 13, 3'b111, 3'b111);
    pll_ok = 1;
    repeat (30) @(negedge clk);
    chk(wr_seen == 3, "R4 lane writes after ready", wr_seen, 3);
    chk(done_cnt == d0, "R5 no done before status ok", done_cnt - d0, 0);
    cmu_ok = 1;
    wait_end();
    chk(done_cnt == d0 + 1, "R5 done pulse", done_cnt - d0, 1);
    chk(to_cnt == t0, "R5 no timeout", to_cnt - t0, 0);
    chk(busy == 0, "R10 busy low at done", busy, 0);
    chk(exp_q.size() == 0, "R10 ignored command left no writes", exp_q.size(), 0);

    // power-down; R7
    d0 = done_cnt;
    push_down_seq();
    fire(0, 1, 0);
    wait_end();
    chk(done_cnt == d0 + 1, "R7 done", done_cnt - d0, 1);
    chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);

    // reset; R8
    d0 = done_cnt; ctrl_n = 0;
    push_reset_seq();
    fire(0, 0, 1);
    wait_end();
    chk(done_cnt == d0 + 1, "R8 done", done_cnt - d0, 1);
    chk(exp_q.size() == 0, "R8 all writes seen", exp_q.size(), 0);
    chk(ctrl_n == 2, "R8 two POR writes", ctrl_n, 2);
    chk(ctrl_log[1] - ctrl_log[0] >= T_POR + 1 && ctrl_log[1] - ctrl_log[0] <= T_POR + 6,
        "R8 POR hold", ctrl_log[1] - ctrl_log[0], T_POR + 4);
    chk(mem_ctrl[29] == 1'b0, "R8 POR cleared", mem_ctrl[29], 0);

    // PLL timeout; R6 R3
    pll_ok = 0;
    d0 = done_cnt; t0 = to_cnt;
    push_rmw(0, 29, 3'b111, 3'b111);
    rd_n = 0;
    fire(1, 0, 0);
    wait_end();
    chk(to_cnt == t0 + 1, "R6 timeout pulse", to_cnt - t0, 1);
    chk(done_cnt == d0, "R6 no done", done_cnt - d0, 0);
    k = (T_TO + T_PLL_POLL) / (T_PLL_POLL + 1);
    exp_reads = 2 + k;
    chk(rd_n == exp_reads, "R6 poll read count", rd_n, exp_reads);
    chk(rd_log[2] - rd_log[1] == T_PLL_POLL + 1, "R3 poll spacing", rd_log[2] - rd_log[1], T_PLL_POLL + 1);
    w0 = wr_seen;
    repeat (20) @(negedge clk);
    chk(wr_seen == w0, "R6 no writes after timeout", wr_seen - w0, 0);
    chk(mem_pll[31:29] == 3'b111, "R6 PLL field kept", mem_pll[31:29], 7);
    chk(busy == 0, "R6 idle after timeout", busy, 0);

    // CMU timeout; R6 R5
    pll_ok = 1; cmu_ok = 0;
    t0 = to_cnt;
    push_rmw(0, 29, 3'b111, 3'b111);
    push_rmw(1, 29, 3'b111, 3'b111);
    push_rmw(1, 13, 3'b111, 3'b111);
    fire(1, 0, 0);
    wait_end();
    chk(to_cnt == t0 + 1, "R6 status timeout", to_cnt - t0, 1);
    chk(exp_q.size() == 0, "R5 writes before status poll", exp_q.size(), 0);

    // simultaneous commands; R11
    cmu_ok = 1;
    d0 = done_cnt;
    push_reset_seq();
    fire(1, 1, 1);
    wait_end();
    chk(done_cnt == d0 + 1 && exp_q.size() == 0, "R11 reset wins", exp_q.size(), 0);
    d0 = done_cnt;
    push_down_seq();
    fire(1, 1, 0);
    wait_end();
    chk(done_cnt == d0 + 1 && exp_q.size() == 0, "R11 down wins over up", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    finished = 1;
    report();
    $finish;
  end

endmodule